// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a parameterized group of level-sensitive peripheral interrupt inputs (32, 64 or 128 lines, packed into 1, 2 or 4 words of 32 bits) and drives one level-sensitive request per CPU. All inputs pass through one shared two-flop synchronizer. The synchronized levels form a single status vector that every CPU sees. Each CPU owns a private bank of enable words. Its request output is high while any line is both high in the status vector and enabled in that CPU's bank. Software therefore steers a source to one CPU, to both CPUs or to neither, purely by choosing which enable bits to set.

The bank has no priority logic, vector output, edge detection or polarity control. A handler reads every status word to find the active sources. Masking is done by reading an enable word, changing it and writing it back. Both kinds of word are laid out with the highest-numbered word at the lowest address. The bus is a plain single-beat interface: a select, a write flag, a byte address and 32-bit data. Read data appears on the clock after the request.

Top module: `lvl_irq_aggregator`

## Requirements
- R1: During and after reset, every enable bit is 0, every CPU request output is low and the read data bus is 0.
- R2: In CPU bank c (base c × 8 × NW bytes, where NW = lines/32), enable word w sits at byte offset 4 × (NW − 1 − w), so the highest word is at offset 0. A write replaces the whole word, and a read returns the value last written.
- R3: Status word w sits at bank offset 4 × NW + 4 × (NW − 1 − w). It returns the synchronized input levels, with bit b of word w being line 32w + b. Every bank returns the same status.
- R4: Writes to status offsets change no enable bit and no status value.
- R5: CPU request c is the OR over all lines of (enable bit in bank c AND synchronized status). It is registered, so an enable write changes it exactly one clock after the write edge.
- R6: The banks are independent. A write to one bank never alters the other bank's enables or request, and one line can be routed to either CPU or to both.
- R7: Addresses whose bank index is NUM_CPUS or higher, or whose two low bits are not zero, are unmapped. Reads of them return 0, and writes to them are ignored.
- R8: Read data is registered. It is valid on the clock after a read request and is 0 on every other clock.
- R9: The inputs are pure levels. When a line falls, its request contribution clears with no latching.
- R10: A change on an input line reaches the CPU request on the third rising clock edge after the change: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Raw level interrupt inputs from peripherals |
| bus_sel_i | input | 1 | Bus access request for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one clock after the request |
| cpu_irq_o | output | NUM_CPUS | Level request per CPU |

## Verification
The interaction that matters most is an enable write and a synchronized input edge that land on the same clock edge. The bench raises a line and then times a write that clears that line's enable bit, so the write is taken on the very edge where the second synchronizer stage picks up the new level. The request output must stay low in every following cycle, because the output register only ever combines enable and status values from the same edge. The bench then restores the enable bit and checks that the request rises exactly one clock after the write.

// File: rtl/agg_pkg.sv
package agg_pkg;
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Which kind of word an access hits after address decoding
    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_ENABLE = 2'd1,
        SLOT_STATUS = 2'd2
    } slot_kind_e;
endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.meta   = raw_i;
        state_d.stable = state_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sync_o = state_q.stable;

    // Checker bookkeeping: counts clock edges since reset, stopping at 2
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    // Two stages of delay from the raw input to the synchronized output
    assert_sync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (sync_o == $past(raw_i, 2)));
endmodule

// File: rtl/cpu_bank.sv
module cpu_bank
    import agg_pkg::*;
#(
    parameter int LINES  = 64,
    parameter int WIDX_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WIDX_W-1:0] wr_word_i,
    input  word_t             wr_data_i,
    input  logic [LINES-1:0]  status_i,
    output logic [LINES-1:0]  en_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [LINES-1:0] en;
        logic             irq;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_i)
            state_d.en[int'(wr_word_i)*WORD_W +: WORD_W] = wr_data_i;
        // Request combines enable and status values from the same edge
        state_d.irq = |(state_q.en & status_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign en_o  = state_q.en;
    assign irq_o = state_q.irq;

    // A write lands in the addressed enable word on the next edge
    assert_wr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o[int'($past(wr_word_i))*WORD_W +: WORD_W] == $past(wr_data_i)));

    // A bank with nothing enabled never raises its request
    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o == '0) |=> !irq_o);

    // With no line active, the request drops on the next edge
    assert_no_source_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i == '0) |=> !irq_o);
endmodule

// File: rtl/lvl_irq_aggregator.sv
module lvl_irq_aggregator
    import agg_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    output logic [NUM_CPUS-1:0]  cpu_irq_o
);
    localparam int NW         = NUM_LINES / WORD_W;
    localparam int WIDX_W     = (NW > 1) ? $clog2(NW) : 1;
    localparam int BANK_SHIFT = $clog2(NW * 8);
    localparam int SLOT_W     = BANK_SHIFT - 2;
    localparam int BANK_W     = ADDR_W - BANK_SHIFT;

    // ---------------- shared synchronizer ----------------
    logic [NUM_LINES-1:0] status;

    lvl_sync #(.W(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_lines_i),
        .sync_o (status)
    );

    // ---------------- address decode ----------------
    logic [BANK_W-1:0] bank_idx;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        align;
    logic              bank_hit;
    slot_kind_e        kind;
    logic [WIDX_W-1:0] word;

    always_comb begin
        bank_idx = bus_addr_i[ADDR_W-1:BANK_SHIFT];
        slot     = bus_addr_i[BANK_SHIFT-1:2];
        align    = bus_addr_i[1:0];
        bank_hit = (int'(bank_idx) < NUM_CPUS) && (align == 2'b00);
        kind     = SLOT_NONE;
        word     = '0;
        if (bank_hit) begin
            if (int'(slot) < NW) begin
                kind = SLOT_ENABLE;
                word = WIDX_W'(NW - 1 - int'(slot));
            end else begin
                kind = SLOT_STATUS;
                word = WIDX_W'(2 * NW - 1 - int'(slot));
            end
        end
    end

    // ---------------- per-CPU banks ----------------
    logic [NUM_CPUS*NUM_LINES-1:0] en_flat;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_sel_i && bus_we_i && (kind == SLOT_ENABLE)
                         && (int'(bank_idx) == c);

        cpu_bank #(.LINES(NUM_LINES), .WIDX_W(WIDX_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (bank_wr),
            .wr_word_i (word),
            .wr_data_i (bus_wdata_i),
            .status_i  (status),
            .en_o      (en_flat[c*NUM_LINES +: NUM_LINES]),
            .irq_o     (cpu_irq_o[c])
        );
    end

    // ---------------- read path ----------------
    typedef struct packed {
        word_t rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.rdata = '0;
        if (bus_sel_i && !bus_we_i) begin
            unique case (kind)
                SLOT_ENABLE: begin
                    for (int c = 0; c < NUM_CPUS; c++)
                        if (int'(bank_idx) == c)
                            rd_d.rdata = en_flat[c*NUM_LINES + int'(word)*WORD_W +: WORD_W];
                end
                SLOT_STATUS: rd_d.rdata = status[int'(word)*WORD_W +: WORD_W];
                default:     rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata_o = rd_q.rdata;

    // ---------------- assertions ----------------
    assert_status_wr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_we_i && kind == SLOT_STATUS) |=> $stable(en_flat));

    assert_unmapped_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_we_i && !bank_hit) |=> $stable(en_flat));

    assert_unmapped_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_we_i && !bank_hit) |=> (bus_rdata_o == '0));

    assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && !bus_we_i) |=> (bus_rdata_o == '0));
endmodule

// File: tb/test_lvl_irq_aggregator.sv
module test_lvl_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] lines = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cpu_irq;

    always #5 clk = ~clk;

    lvl_irq_aggregator #(.NUM_LINES(64), .NUM_CPUS(2), .ADDR_W(8)) i_lvl_irq_aggregator (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_lines_i (lines),
        .bus_sel_i   (bus_sel),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .cpu_irq_o   (cpu_irq)
    );

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;

    // Monitor: a read issued at an edge shows its data after that edge
    always @(posedge clk) rd_seen <= bus_sel && !bus_we;

    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t e;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: read data with empty queue, actual %h", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                if (bus_rdata !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: rdata actual %h expected %h", e.tag, bus_rdata, e.val);
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t item;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        item.val = e; item.tag = tag;
        exp_q.push_back(item);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_irq(input logic [1:0] e, input string tag);
        n_cmp++;
        if (cpu_irq !== e) begin
            n_bad++;
            $display("FAIL %s: cpu_irq actual %b expected %b", tag, cpu_irq, e);
        end
    endtask

    task automatic check_rdata(input logic [31:0] e, input string tag);
        n_cmp++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s: rdata actual %h expected %h", tag, bus_rdata, e);
        end
    endtask

    task automatic set_line(input int idx, input logic v);
        @(negedge clk);
        lines[idx] = v;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_neg(3);
        check_irq(2'b00, "R1 irq in reset");
        check_rdata(32'h0, "R1 rdata in reset");
        rst_n = 1'b1;
        wait_neg(1);

        // R1: enables cleared
        bus_read(8'h00, 32'h0, "R1 bank0 en w1");
        bus_read(8'h04, 32'h0, "R1 bank0 en w0");
        bus_read(8'h14, 32'h0, "R1 bank1 en w0");

        // R2: reversed enable layout
        bus_write(8'h04, 32'h0000_0005);
        bus_read(8'h04, 32'h0000_0005, "R2 en w0 at offset 4");
        bus_read(8'h00, 32'h0, "R2 en w1 untouched");
        bus_write(8'h00, 32'h25A5_0000);
        bus_read(8'h00, 32'h25A5_0000, "R2 en w1 at offset 0");
        // R8: data only on the clock after a read
        wait_neg(1);
        check_rdata(32'h0, "R8 idle rdata");
        check_irq(2'b00, "R5 no lines active");

        // R10/R5/R6: line 2 is enabled in bank0 only
        set_line(2, 1'b1);
        wait_neg(2);
        check_irq(2'b00, "R10 not before third edge");
        wait_neg(1);
        check_irq(2'b01, "R10 R5 R6 arrives on third edge");

        // R3: status layout, shared across banks
        bus_read(8'h0C, 32'h0000_0004, "R3 bank0 status w0");
        bus_read(8'h1C, 32'h0000_0004, "R3 bank1 status w0");
        bus_read(8'h08, 32'h0, "R3 bank0 status w1");

        // R4: status writes ignored
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h0C, 32'h0000_0004, "R4 status unchanged");
        bus_read(8'h04, 32'h0000_0005, "R4 enable unchanged");
        check_irq(2'b01, "R4 irq unchanged");

        // R9: level drop clears the request
        set_line(2, 1'b0);
        wait_neg(3);
        check_irq(2'b00, "R9 request follows line low");

        // R6: route line 63 to bank1 only, then both
        bus_write(8'h10, 32'h8000_0000);
        set_line(63, 1'b1);
        wait_neg(3);
        check_irq(2'b10, "R6 line63 to cpu1 only");
        bus_read(8'h08, 32'h8000_0000, "R3 status w1 bit31 is line63");
        bus_write(8'h00, 32'h8000_0000);
        wait_neg(1);
        check_irq(2'b11, "R6 line63 to both");
        bus_read(8'h14, 32'h0, "R6 bank1 en w0 untouched");

        // R7: unmapped space
        bus_read(8'h20, 32'h0, "R7 unmapped bank read");
        bus_read(8'hF4, 32'h0, "R7 high unmapped read");
        bus_read(8'h06, 32'h0, "R7 misaligned read");
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_write(8'h05, 32'hFFFF_FFFF);
        bus_read(8'h04, 32'h0000_0005, "R7 bank0 en w0 kept");
        bus_read(8'h10, 32'h8000_0000, "R7 bank1 en w1 kept");

        // Clean up line 63 routing
        set_line(63, 1'b0);
        bus_write(8'h00, 32'h0);
        wait_neg(3);
        check_irq(2'b00, "R9 all quiet");

        // R5: enable clear on the same edge the line reaches status
        @(negedge clk);
        lines[0] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_0004;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check_irq(2'b00, "R5 same-edge clear stays low");
            @(negedge clk);
        end
        // R5: re-enable, request one clock after the write edge
        bus_write(8'h04, 32'h0000_0005);
        check_irq(2'b00, "R5 not on write edge");
        wait_neg(1);
        check_irq(2'b01, "R5 one clock after write");

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_irq(2'b00, "R1 irq cleared by reset");
        rst_n = 1'b1;
        bus_read(8'h04, 32'h0, "R1 en cleared by reset");
        wait_neg(3);
        check_irq(2'b00, "R1 no request after reset");

        wait_neg(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule